// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the clock sent to an SD card from the base clock of its host controller. One 32-bit control word sets it up, loaded through a single write strobe. The word selects the divide ratio, gates the output with an enable bit, and can turn on an automatic stop mode.

The ratio comes from three sources:
- a one-hot field in bits [7:0], giving powers of two from 4 to 512;
- a bypass bit, which gives divide-by-1;
- an optional long-divide bit, which gives divide-by-1024.

With none of these bits set, the ratio is 2. In automatic stop mode the card clock is held off whenever the bus-activity input shows that no transfer is in progress.

Every change to the output is glitch free. A high phase always runs to its full length. A new ratio is taken only at the start of a low phase. While the clock is disabled or stopped, the output rests low.

Top module: `sdclk_divider`

## Requirements
- R1: After reset the control word is zero and `card_clk` stays low. While the enable bit (bit 8) is clear, `card_clk` produces no pulse, whatever else the word holds.
- R2: With the enable bit set and bits [7:0], 10 and 16 all clear, `card_clk` has a period of 2 base cycles and is high for 1.
- R3: With only bit i of [7:0] set (i = 0..7), the period is 2^(i+2) base cycles and the output is high for exactly half of it.
- R4: Bit 10 selects bypass. `card_clk` then follows the base clock: one pulse per base cycle, high while the base clock is high.
- R5: Bit 16 selects a ratio of 1024, giving a period of 1024 base cycles with 512 high.
- R6: When several selector bits are set, bit 10 wins, then bit 16, then the highest set bit of [7:0].
- R7: Clearing the enable bit while the clock runs lets the current high phase finish at full length. The output then stays low. No high pulse is ever shorter than half a period of a legal ratio.
- R8: A ratio written while the clock runs takes effect at the next low-phase start. Every high pulse is a full half period of either the old or the new ratio.
- R9: With bit 9 (automatic stop) set, `card_clk` is held low while `bus_busy` is low. It runs at the selected ratio while `bus_busy` is high.
- R10: With bit 9 clear, `bus_busy` has no effect, and the clock runs while it is low.
- R11: With two or more bits of [7:0] set and bits 10 and 16 clear, the ratio follows the highest set bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word value |
| bus_busy | input | 1 | High while a card transfer is in progress |
| card_clk | output | 1 | Generated card clock |

## Verification
The bench runs every single-bit encoding of the divide field, the empty field, bypass and the long divide. For each one it measures the period and the high time, which separates one ratio from the next and exposes any duty-cycle error. Words with several selector bits set, both directed and random, show whether priority is resolved correctly rather than by a wrong bit order. Toggling the enable bit, changing the ratio on the fly and toggling the activity input under automatic stop exercise the boundary logic. Throughout, a pulse-width monitor flags any runt.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    // Control word bit positions decoded by the divider
    localparam int EN_BIT   = 8;   // card clock enable
    localparam int AUTO_BIT = 9;   // stop clock while bus idle
    localparam int BYP_BIT  = 10;  // divide-by-1
    localparam int LONG_BIT = 16;  // divide-by-1024 (extended variant)
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter int CTRL_W   = 32,
    parameter int ONEHOT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    input  logic                bus_busy,
    output logic [ONEHOT_W-1:0] div_sel,
    output logic                bypass,
    output logic                long_div,
    output logic                en,
    output logic                run
);
    localparam logic [CTRL_W-1:0] USED_MASK =
        CTRL_W'((1 << ONEHOT_W) - 1) | (CTRL_W'(1) << EN_BIT) | (CTRL_W'(1) << AUTO_BIT)
        | (CTRL_W'(1) << BYP_BIT) | (CTRL_W'(1) << LONG_BIT);

    typedef struct packed {
        logic [ONEHOT_W-1:0] div;
        logic                en;
        logic                auto_stop;
        logic                bypass;
        logic                long_div;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  wdata_unused;

    assign wdata_unused = ^(wr_data & ~USED_MASK);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.div       = wr_data[ONEHOT_W-1:0];
            ctrl_d.en        = wr_data[EN_BIT];
            ctrl_d.auto_stop = wr_data[AUTO_BIT];
            ctrl_d.bypass    = wr_data[BYP_BIT];
            ctrl_d.long_div  = wr_data[LONG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign div_sel  = ctrl_q.div;
    assign bypass   = ctrl_q.bypass;
    assign long_div = ctrl_q.long_div;
    assign en       = ctrl_q.en;
    assign run      = ctrl_q.en && (!ctrl_q.auto_stop || bus_busy);
endmodule

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec #(
    parameter int ONEHOT_W = 8,
    parameter bit EXT_LONG = 1'b1,
    parameter int IDX_W    = 4
) (
    input  logic [ONEHOT_W-1:0] div_sel,
    input  logic                bypass,
    input  logic                long_div,
    output logic [IDX_W-1:0]    idx      // 0: bypass, k>0: ratio 2^k
);
    logic long_hit;

    generate
        if (EXT_LONG) begin : g_long
            assign long_hit = long_div;
        end else begin : g_no_long
            logic long_unused;
            assign long_unused = long_div;
            assign long_hit    = 1'b0;
        end
    endgenerate

    always_comb begin
        idx = IDX_W'(1);
        for (int i = 0; i < ONEHOT_W; i++) begin
            if (div_sel[i]) idx = IDX_W'(i + 2);
        end
        if (long_hit) idx = IDX_W'(ONEHOT_W + 2);
        if (bypass)   idx = '0;
    end
endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IDX_W-1:0] sel_idx,
    output logic             phase,
    output logic [IDX_W-1:0] act,
    output logic             byp_gate,
    output logic             card_clk
);
    typedef struct packed {
        logic             phase;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] act;
        logic             byp;
    } st_t;

    st_t              st_d, st_q;
    logic             byp_gate_q;
    logic             load_ok;
    logic [IDX_W-1:0] eff;
    logic [CNT_W:0]   half_w;
    logic [CNT_W:0]   half_m1_w;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        st_d      = st_q;
        load_ok   = !st_q.phase && (st_q.cnt == '0) && !byp_gate_q && !st_q.byp;
        eff       = load_ok ? sel_idx : st_q.act;
        half_w    = {{CNT_W{1'b0}}, 1'b1} << (eff - IDX_W'(1));
        half_m1_w = half_w - (CNT_W+1)'(1);
        half_m1   = half_m1_w[CNT_W-1:0];
        if (load_ok) st_d.act = sel_idx;
        st_d.byp = run && (sel_idx == '0) && (load_ok || st_q.act == '0);
        if (eff == '0) begin
            st_d.phase = 1'b0;
            st_d.cnt   = '0;
        end else if (st_q.phase) begin
            if (st_q.cnt == half_m1) begin
                st_d.phase = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == half_m1) begin
            st_d.phase = 1'b1;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // bypass gate changes only while the base clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) byp_gate_q <= 1'b0;
        else        byp_gate_q <= st_q.byp;
    end

    assign phase    = st_q.phase;
    assign act      = st_q.act;
    assign byp_gate = byp_gate_q;
    assign card_clk = (byp_gate_q & clk) | st_q.phase;
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
    parameter int CTRL_W   = 32,
    parameter int ONEHOT_W = 8,
    parameter bit EXT_LONG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              bus_busy,
    output logic              card_clk
);
    localparam int IDX_W = $clog2(ONEHOT_W + 3);
    localparam int CNT_W = ONEHOT_W + 1;

    logic [ONEHOT_W-1:0] div_sel;
    logic                bypass, long_div, en_q, run;
    logic [IDX_W-1:0]    sel_idx, act_q;
    logic                phase_q, byp_gate_q;

    sdclk_ctrl_reg #(.CTRL_W(CTRL_W), .ONEHOT_W(ONEHOT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .bus_busy(bus_busy), .div_sel(div_sel), .bypass(bypass),
        .long_div(long_div), .en(en_q), .run(run)
    );

    sdclk_ratio_dec #(.ONEHOT_W(ONEHOT_W), .EXT_LONG(EXT_LONG), .IDX_W(IDX_W)) i_dec (
        .div_sel(div_sel), .bypass(bypass), .long_div(long_div), .idx(sel_idx)
    );

    sdclk_phase_gen #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .sel_idx(sel_idx),
        .phase(phase_q), .act(act_q), .byp_gate(byp_gate_q), .card_clk(card_clk)
    );
endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_bit,
    input logic             run,
    input logic             phase,
    input logic [IDX_W-1:0] act,
    input logic             byp_gate
);
    logic [15:0] hi_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_len_q <= '0;
        else if (phase) hi_len_q <= hi_len_q + 16'd1;
        else            hi_len_q <= '0;
    end

    function automatic int half_of(logic [IDX_W-1:0] k);
        return 1 << (int'(k) - 1);
    endfunction

    AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bit && !phase) |=> !phase);                                   // R1
    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase) |-> $past(run));                                      // R9
    AST_HIGH_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(phase) && act != '0) |-> (int'(hi_len_q) == half_of(act))); // R7
    AST_RATIO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && $past(phase)) |-> $stable(act));                          // R8
    AST_BYPASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(byp_gate && phase));                                              // R4
endmodule

bind sdclk_divider sdclk_divider_chk #(.IDX_W(IDX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en_bit(en_q), .run(run),
    .phase(phase_q), .act(act_q), .byp_gate(byp_gate_q)
);

// File: tb/test_sdclk_divider.sv
module test_sdclk_divider;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] EN   = 32'h0000_0100;
    localparam logic [31:0] AUTO = 32'h0000_0200;
    localparam logic [31:0] BYP  = 32'h0000_0400;
    localparam logic [31:0] LONG = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_busy = 1'b0;
    logic        card_clk;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int runts = 0;
    realtime last_rise = 0;

    sdclk_divider i_sdclk_divider (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_busy(bus_busy), .card_clk(card_clk)
    );

    always #10 clk = ~clk;

    always @(posedge card_clk) begin
        pulses++;
        last_rise = $realtime;
    end

    // R7: every high pulse is 10 ns (bypass) or a power of two of base cycles
    always @(negedge card_clk) begin
        int w;
        int n;
        w = int'($realtime - last_rise);
        n = w / 20;
        if (!(w == 10 || (n >= 1 && n <= 512 && n * 20 == w && (n & (n - 1)) == 0)))
            runts++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int exp_ratio(input logic [31:0] c);
        if (c[10]) return 1;
        if (c[16]) return 1024;
        for (int i = 7; i >= 0; i--) if (c[i]) return 1 << (i + 2);
        return 2;
    endfunction

    task automatic measure(input string req, input int ratio);
        realtime t0, t1, t2;
        @(posedge card_clk);
        @(posedge card_clk);
        @(posedge card_clk); t0 = $realtime;
        @(negedge card_clk); t1 = $realtime;
        @(posedge card_clk); t2 = $realtime;
        check(int'(t2 - t0) == ratio * 20, {req, " period ns"}, int'(t2 - t0), ratio * 20);
        check(int'(t1 - t0) == ratio * 10, {req, " high ns"}, int'(t1 - t0), ratio * 10);
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        int p0;
        int highs;
        p0 = pulses;
        highs = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (card_clk) highs++;
        end
        check(pulses == p0, {req, " pulses while off"}, pulses - p0, 0);
        check(highs == 0, {req, " high samples while off"}, highs, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and disabled word
        expect_quiet("R1 reset", 30);
        wr(32'h0000_00FF | BYP);
        expect_quiet("R1 enable clear", 60);

        // R2: empty field -> divide by 2
        wr(EN);
        measure("R2", 2);

        // R3: each one-hot bit
        for (int i = 0; i < 8; i++) begin
            wr(EN | (32'd1 << i));
            measure($sformatf("R3 bit%0d", i), 1 << (i + 2));
        end

        // R4: bypass
        wr(EN | BYP);
        measure("R4", 1);

        // R5: long divide
        wr(EN | LONG);
        measure("R5", 1024);

        // R6: priority among selector bits
        wr(EN | BYP | LONG | 32'h81);
        measure("R6 bypass wins", 1);
        wr(EN | LONG | 32'h81);
        measure("R6 long wins", 1024);

        // R11: highest one-hot bit wins
        wr(EN | 32'h0A);
        measure("R11", 32);

        // R8: on-the-fly change without clearing enable
        wr(EN | 32'h02);
        measure("R8 before", 8);
        @(posedge card_clk);
        wr(EN | 32'h01);
        measure("R8 after", 4);

        // R7: clear enable during a high phase
        wr(EN | 32'h10);
        measure("R7 running", 64);
        @(posedge card_clk);
        wr(32'h10);
        repeat (40) @(negedge clk);
        check(card_clk == 1'b0, "R7 low after disable", int'(card_clk), 0);
        expect_quiet("R7", 200);

        // R9: automatic stop follows bus activity
        bus_busy = 1'b0;
        wr(EN | AUTO | 32'h01);
        repeat (10) @(negedge clk);
        expect_quiet("R9 idle", 100);
        bus_busy = 1'b1;
        measure("R9 busy", 4);
        bus_busy = 1'b0;
        repeat (10) @(negedge clk);
        expect_quiet("R9 idle again", 100);

        // R10: activity input ignored without automatic stop
        wr(EN | 32'h01);
        measure("R10", 4);

        // R6: random words against the priority model
        for (int t = 0; t < 16; t++) begin
            d = $urandom;
            d = (d | EN) & ~AUTO;
            if (($urandom % 4) != 0) d = d & ~LONG;
            wr(d);
            measure($sformatf("R6 random %08h", d), exp_ratio(d));
        end

        check(runts == 0, "R7 runt pulses", runts, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule